// File: doc/BRIEF.md
# Transmit Channel Command Controller

This block runs one transmit channel that sends frames from a ring of transmit descriptors. Each descriptor holds a ready flag, a wrap flag and a byte length. Descriptor `i` owns the buffer region that starts at byte address `i*MAX_LEN` of an internal byte memory. The host fills the memory and the descriptors through simple write ports. It steers the channel with three commands written to a command port: STOP, RESTART and INIT-PARAMETERS. Bytes leave the block on a valid/ready stream, with a last flag on the final byte of each frame.

A small sequencer has three states. **HALT** is idle: no descriptor is read and nothing is sent. **FETCH** examines the descriptor selected by the current pointer. **SEND** streams that descriptor's buffer. The named transitions are:
- *start* (HALT→FETCH): the run flag is set and `tx_en` is high.
- *accept* (FETCH→SEND): the selected descriptor is ready.
- *poll* (FETCH→FETCH): the selected descriptor is not ready.
- *beat* (SEND→SEND): a non-final byte is taken.
- *advance* (SEND→FETCH): the final byte is taken. The ready flag is cleared and the pointer steps on.
- *halt* (any→HALT): caused by STOP, by a transmit error, by INIT-PARAMETERS while disabled, or by `tx_en` going low.

A stop or error in mid-frame leaves the pointer where it is, so the next RESTART sends the interrupted descriptor again from its first byte.

Top module: `tx_cmd_ctrl`

## Requirements
- R1: After reset, `out_valid`, `cmd_busy` and `cmd_err` are 0 and `cur_ptr` is 0. All descriptors are not ready. The channel stays in HALT until a RESTART is executed.
- R2: The port latches a command write seen with `cmd_busy` low. `cmd_busy` is high for the next two cycles: the command executes at the first of the following edges, and `cmd_busy` falls one cycle after that. A write made while `cmd_busy` is high is ignored.
- R3: `cmd_op` encodes 2'b00 as STOP, 2'b01 as RESTART and 2'b10 as INIT-PARAMETERS. The value 2'b11 changes nothing, including `cmd_err`.
- R4: When RESTART executes with `tx_en` high, the channel resumes from the descriptor at `cur_ptr`, and the first byte is valid two edges later. When RESTART executes with `tx_en` low, the channel waits and starts only once `tx_en` is high.
- R5: A descriptor is sent only while its ready flag is 1. In FETCH, a not-ready descriptor is polled and no byte is output.
- R6: Descriptor `i` with length `L` (1..MAX_LEN) outputs memory bytes `i*MAX_LEN` through `i*MAX_LEN+L-1` in order, one per handshake. `out_last` marks byte `L-1`. While `out_valid` is high and `out_ready` is low, the byte is held.
- R7: After the final handshake, the descriptor's ready flag is cleared. `cur_ptr` then becomes 0 if the wrap flag is 1, and otherwise `cur_ptr+1` modulo NUM_DESC.
- R8: An executed STOP drops `out_valid` from the next cycle and leaves `cur_ptr` unadvanced. No descriptor is fetched until a RESTART, and that RESTART resends the interrupted frame from its first byte.
- R9: A `tx_err` pulse has the same effect as a STOP: the channel halts, `cur_ptr` is kept, and the channel waits for a RESTART.
- R10: INIT-PARAMETERS executed while `tx_en` is low sets `cur_ptr` to 0 and clears the run flag, so raising `tx_en` alone starts nothing.
- R11: INIT-PARAMETERS executed while `tx_en` is high is ignored and sets `cmd_err`. The next executed STOP, RESTART or accepted INIT-PARAMETERS clears `cmd_err`.
- R12: `tx_en` going low halts the channel without advancing `cur_ptr`. If no stop was issued, the frame is resent from its first byte once `tx_en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| tx_err | input | 1 | Transmit error pulse |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 2 | Command opcode |
| cmd_busy | output | 1 | Command port busy |
| cmd_err | output | 1 | Rejected INIT-PARAMETERS flag |
| desc_wr | input | 1 | Descriptor write strobe (sets ready) |
| desc_idx | input | PTR_W | Descriptor index |
| desc_wrap | input | 1 | Wrap flag written |
| desc_len | input | LEN_W | Frame length written |
| mem_wr | input | 1 | Buffer memory write strobe |
| mem_addr | input | ADDR_W | Buffer memory byte address |
| mem_wdata | input | DATA_W | Buffer memory write byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Output byte |
| out_last | output | 1 | Final byte of frame |
| cur_ptr | output | PTR_W | Current descriptor pointer |

## Verification
The bound checker watches the following rules on every cycle:
- the shape of the command-busy pulse;
- that the byte is held under back-pressure;
- that `out_valid` is low after a stop, an error or a disable;
- that a rejected INIT-PARAMETERS raises `cmd_err` and that opcode 2'b11 leaves it alone;
- that the pointer changes only after a final handshake or an INIT-PARAMETERS.

Only the bench scenarios can show that a stopped frame is resent in full from byte 0 after RESTART, and that descriptors are visited in ring order with wrap. The same holds for polling of a not-ready descriptor, a RESTART issued while disabled taking effect later, and a write made during busy being lost. The bench shows these by comparing every output with a behavioural model on every clock.

// File: rtl/txc_pkg.sv
package txc_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2
    } txc_state_e;

    typedef enum logic [1:0] {
        OP_STOP    = 2'b00,
        OP_RESTART = 2'b01,
        OP_INIT    = 2'b10,
        OP_NOP     = 2'b11
    } txc_op_e;

endpackage

// File: rtl/txc_cmd_port.sv
module txc_cmd_port
    import txc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [1:0] cmd_op,
    output logic       cmd_busy,
    output logic       exec_vld,
    output txc_op_e    exec_op
);
    logic    pend_q;
    logic    hold_q;
    txc_op_e op_q;
    logic    take;

    assign take = cmd_wr && !cmd_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            hold_q <= 1'b0;
            op_q   <= OP_NOP;
        end else begin
            pend_q <= take;
            hold_q <= pend_q;
            if (take) op_q <= txc_op_e'(cmd_op);
        end
    end

    assign cmd_busy = pend_q | hold_q;
    assign exec_vld = pend_q;
    assign exec_op  = op_q;
endmodule

// File: rtl/txc_ring_store.sv
module txc_ring_store #(
    parameter int NUM_DESC = 4,
    parameter int MAX_LEN  = 8,
    parameter int DATA_W   = 8,
    localparam int PTR_W   = $clog2(NUM_DESC),
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int OFF_W   = $clog2(MAX_LEN),
    localparam int DEPTH   = NUM_DESC * MAX_LEN,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic              wr_wrap,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic              clr_en,
    input  logic [PTR_W-1:0]  clr_idx,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic [PTR_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              rd_ready,
    output logic              rd_wrap,
    output logic [LEN_W-1:0]  rd_len,
    output logic [DATA_W-1:0] rd_byte
);
    logic             rdy_arr  [NUM_DESC];
    logic             wrap_arr [NUM_DESC];
    logic [LEN_W-1:0] len_arr  [NUM_DESC];
    logic [DATA_W-1:0] mem_q   [DEPTH];
    logic [ADDR_W-1:0] rd_addr;

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
        logic             rdy_r;
        logic             wrap_r;
        logic [LEN_W-1:0] len_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdy_r  <= 1'b0;
                wrap_r <= 1'b0;
                len_r  <= '0;
            end else if (wr_en && wr_idx == PTR_W'(g)) begin
                rdy_r  <= 1'b1;
                wrap_r <= wr_wrap;
                len_r  <= wr_len;
            end else if (clr_en && clr_idx == PTR_W'(g)) begin
                rdy_r  <= 1'b0;
            end
        end
        assign rdy_arr[g]  = rdy_r;
        assign wrap_arr[g] = wrap_r;
        assign len_arr[g]  = len_r;
    end

    always_ff @(posedge clk) begin
        if (mem_wr) mem_q[mem_addr] <= mem_wdata;
    end

    assign rd_addr  = ADDR_W'(int'(rd_idx) * MAX_LEN + int'(rd_off));
    assign rd_ready = rdy_arr[rd_idx];
    assign rd_wrap  = wrap_arr[rd_idx];
    assign rd_len   = len_arr[rd_idx];
    assign rd_byte  = mem_q[rd_addr];
endmodule

// File: rtl/tx_cmd_ctrl.sv
module tx_cmd_ctrl
    import txc_pkg::*;
#(
    parameter int NUM_DESC = 4,
    parameter int MAX_LEN  = 8,
    parameter int DATA_W   = 8,
    localparam int PTR_W   = $clog2(NUM_DESC),
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int OFF_W   = $clog2(MAX_LEN),
    localparam int ADDR_W  = $clog2(NUM_DESC * MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tx_err,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_op,
    output logic              cmd_busy,
    output logic              cmd_err,
    input  logic              desc_wr,
    input  logic [PTR_W-1:0]  desc_idx,
    input  logic              desc_wrap,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic [PTR_W-1:0]  cur_ptr
);
    txc_state_e       state_q, state_n;
    logic [PTR_W-1:0] ptr_q, ptr_n, ptr_step;
    logic [OFF_W-1:0] cnt_q, cnt_n;
    logic             run_q, run_n;
    logic             err_q, err_n;
    logic             clr_en;
    logic             frame_end;
    logic             exec_vld;
    txc_op_e          exec_op;
    logic             rd_ready, rd_wrap;
    logic [LEN_W-1:0] rd_len;
    logic [DATA_W-1:0] rd_byte;

    txc_cmd_port u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_op   (cmd_op),
        .cmd_busy (cmd_busy),
        .exec_vld (exec_vld),
        .exec_op  (exec_op)
    );

    txc_ring_store #(
        .NUM_DESC (NUM_DESC),
        .MAX_LEN  (MAX_LEN),
        .DATA_W   (DATA_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (desc_wr),
        .wr_idx    (desc_idx),
        .wr_wrap   (desc_wrap),
        .wr_len    (desc_len),
        .clr_en    (clr_en),
        .clr_idx   (ptr_q),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rd_idx    (ptr_q),
        .rd_off    (cnt_q),
        .rd_ready  (rd_ready),
        .rd_wrap   (rd_wrap),
        .rd_len    (rd_len),
        .rd_byte   (rd_byte)
    );

    assign frame_end = (LEN_W'(cnt_q) + LEN_W'(1)) >= rd_len;
    assign ptr_step  = (rd_wrap || ptr_q == PTR_W'(NUM_DESC - 1)) ? '0 : ptr_q + 1'b1;

    // next-state: sequencer, then error, then command execution
    always_comb begin
        state_n = state_q;
        ptr_n   = ptr_q;
        cnt_n   = cnt_q;
        run_n   = run_q;
        err_n   = err_q;
        clr_en  = 1'b0;

        unique case (state_q)
            ST_HALT: begin
                if (run_q && tx_en) state_n = ST_FETCH;
            end
            ST_FETCH: begin
                if (!tx_en) begin
                    state_n = ST_HALT;
                end else if (rd_ready) begin
                    state_n = ST_SEND;
                    cnt_n   = '0;
                end
            end
            ST_SEND: begin
                if (!tx_en) begin
                    state_n = ST_HALT;
                    cnt_n   = '0;
                end else if (out_ready) begin
                    if (frame_end) begin
                        clr_en  = 1'b1;
                        ptr_n   = ptr_step;
                        state_n = ST_FETCH;
                        cnt_n   = '0;
                    end else begin
                        cnt_n   = cnt_q + 1'b1;
                    end
                end
            end
            default: state_n = ST_HALT;
        endcase

        if (tx_err) begin
            state_n = ST_HALT;
            run_n   = 1'b0;
            cnt_n   = '0;
            ptr_n   = ptr_q;
            clr_en  = 1'b0;
        end

        if (exec_vld) begin
            unique case (exec_op)
                OP_STOP: begin
                    state_n = ST_HALT;
                    run_n   = 1'b0;
                    cnt_n   = '0;
                    ptr_n   = ptr_q;
                    clr_en  = 1'b0;
                    err_n   = 1'b0;
                end
                OP_RESTART: begin
                    if (!tx_err) run_n = 1'b1;
                    err_n = 1'b0;
                end
                OP_INIT: begin
                    if (tx_en) begin
                        err_n = 1'b1;
                    end else begin
                        state_n = ST_HALT;
                        run_n   = 1'b0;
                        cnt_n   = '0;
                        ptr_n   = '0;
                        clr_en  = 1'b0;
                        err_n   = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            ptr_q   <= '0;
            cnt_q   <= '0;
            run_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            ptr_q   <= ptr_n;
            cnt_q   <= cnt_n;
            run_q   <= run_n;
            err_q   <= err_n;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_SEND);
        out_last  = out_valid && frame_end;
        out_data  = rd_byte;
        cur_ptr   = ptr_q;
        cmd_err   = err_q;
    end
endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
    parameter int PTR_W  = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              tx_err,
    input logic              cmd_wr,
    input logic              cmd_busy,
    input logic              cmd_err,
    input logic              mem_wr,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_last,
    input logic [DATA_W-1:0] out_data,
    input logic [PTR_W-1:0]  cur_ptr,
    input logic              exec_vld,
    input logic [1:0]        exec_op
);
    AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !cmd_busy |=> cmd_busy); // R2
    AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |=> cmd_busy ##1 !cmd_busy); // R2
    AST_NOP_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        exec_vld && exec_op == 2'b11 |=> $stable(cmd_err)); // R3
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(tx_en)); // R4
    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && tx_en && !tx_err && !exec_vld && !mem_wr
        |=> out_valid && $stable(out_data)); // R6
    AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_ptr) |-> $past(out_valid && out_ready && out_last)
                              || $past(exec_vld && exec_op == 2'b10)); // R7
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        exec_vld && exec_op == 2'b00 |=> !out_valid); // R8
    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |=> !out_valid); // R9
    AST_INIT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        exec_vld && exec_op == 2'b10 && tx_en |=> cmd_err); // R11
    AST_DISABLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !out_valid); // R12
endmodule

bind tx_cmd_ctrl txc_checker #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .tx_err    (tx_err),
    .cmd_wr    (cmd_wr),
    .cmd_busy  (cmd_busy),
    .cmd_err   (cmd_err),
    .mem_wr    (mem_wr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_data  (out_data),
    .cur_ptr   (cur_ptr),
    .exec_vld  (exec_vld),
    .exec_op   (exec_op)
);

// File: tb/tb_tx_cmd_ctrl.sv
module tb_tx_cmd_ctrl;
    localparam int ND = 4, ML = 8, DW = 8;
    localparam int PW = $clog2(ND), LW = $clog2(ML + 1), AW = $clog2(ND * ML);

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_en = 1'b0, tx_err = 1'b0, cmd_wr = 1'b0;
    logic [1:0] cmd_op = 2'b11;
    logic cmd_busy, cmd_err;
    logic desc_wr = 1'b0, desc_wrap = 1'b0;
    logic [PW-1:0] desc_idx = '0;
    logic [LW-1:0] desc_len = '0;
    logic mem_wr = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic out_valid, out_ready = 1'b1, out_last;
    logic [DW-1:0] out_data;
    logic [PW-1:0] cur_ptr;

    always #5 clk = ~clk;

    tx_cmd_ctrl #(.NUM_DESC(ND), .MAX_LEN(ML), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_err(tx_err),
        .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_busy(cmd_busy), .cmd_err(cmd_err),
        .desc_wr(desc_wr), .desc_idx(desc_idx), .desc_wrap(desc_wrap), .desc_len(desc_len),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .cur_ptr(cur_ptr)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0, bp_mode = 0;
    string cur_req = "R1";
    logic [7:0] lfsr = 8'hA5;

    // behavioural reference model
    int m_rdy[ND], m_wrap[ND], m_len[ND], m_mem[ND*ML];
    int m_state = 0, m_ptr = 0, m_cnt = 0, m_run = 0, m_err = 0;
    int m_pend = 0, m_hold = 0, m_pop = 3;

    always @(posedge clk) begin : model
        int ns, np, nc, nr, ne, busy_old;
        bit clr;
        if (!rst_n) begin
            for (int i = 0; i < ND; i++) begin m_rdy[i] = 0; m_wrap[i] = 0; m_len[i] = 0; end
            m_state = 0; m_ptr = 0; m_cnt = 0; m_run = 0; m_err = 0;
            m_pend = 0; m_hold = 0; m_pop = 3;
        end else begin
            ns = m_state; np = m_ptr; nc = m_cnt; nr = m_run; ne = m_err; clr = 0;
            if (m_state == 0) begin
                if (m_run != 0 && tx_en) ns = 1;
            end else if (m_state == 1) begin
                if (!tx_en) ns = 0;
                else if (m_rdy[m_ptr] != 0) begin ns = 2; nc = 0; end
            end else begin
                if (!tx_en) begin ns = 0; nc = 0; end
                else if (out_ready) begin
                    if (m_cnt + 1 >= m_len[m_ptr]) begin
                        clr = 1; ns = 1; nc = 0;
                        np = (m_wrap[m_ptr] != 0) ? 0 : (m_ptr + 1) % ND;
                    end else nc = m_cnt + 1;
                end
            end
            if (tx_err) begin ns = 0; nr = 0; nc = 0; np = m_ptr; clr = 0; end
            if (m_pend != 0) begin
                if (m_pop == 0) begin ns = 0; nr = 0; nc = 0; np = m_ptr; clr = 0; ne = 0; end
                else if (m_pop == 1) begin if (!tx_err) nr = 1; ne = 0; end
                else if (m_pop == 2) begin
                    if (tx_en) ne = 1;
                    else begin ns = 0; nr = 0; nc = 0; np = 0; clr = 0; ne = 0; end
                end
            end
            if (clr) m_rdy[m_ptr] = 0;
            if (desc_wr) begin
                m_rdy[desc_idx] = 1; m_wrap[desc_idx] = int'(desc_wrap); m_len[desc_idx] = int'(desc_len);
            end
            if (mem_wr) m_mem[mem_addr] = int'(mem_wdata);
            busy_old = m_pend | m_hold;
            m_hold = m_pend;
            if (cmd_wr && busy_old == 0) begin m_pend = 1; m_pop = int'(cmd_op); end
            else m_pend = 0;
            m_state = ns; m_ptr = np; m_cnt = nc; m_run = nr; m_err = ne;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison with the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "cmd_busy", int'(cmd_busy), (m_pend | m_hold) != 0 ? 1 : 0);
            check(cur_req, "cmd_err", int'(cmd_err), m_err);
            check(cur_req, "cur_ptr", int'(cur_ptr), m_ptr);
            check(cur_req, "out_valid", int'(out_valid), m_state == 2 ? 1 : 0);
            if (m_state == 2) begin
                check(cur_req, "out_data", int'(out_data), m_mem[m_ptr*ML + m_cnt]);
                check(cur_req, "out_last", int'(out_last), (m_cnt + 1 >= m_len[m_ptr]) ? 1 : 0);
            end
        end
    end

    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= bp_mode ? lfsr[0] : 1'b1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired, run hung");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cmd(logic [1:0] op);
        @(negedge clk); cmd_wr = 1'b1; cmd_op = op;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic put_desc(int idx, int len, bit wrap);
        @(negedge clk); desc_wr = 1'b1; desc_idx = PW'(idx); desc_len = LW'(len); desc_wrap = wrap;
        @(negedge clk); desc_wr = 1'b0;
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 60 && !out_valid; k++) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", "reset out_valid", int'(out_valid), 0);
        check("R1", "reset cur_ptr", int'(cur_ptr), 0);
        check("R1", "reset cmd_busy", int'(cmd_busy), 0);
        check("R1", "reset cmd_err", int'(cmd_err), 0);

        for (int i = 0; i < ND*ML; i++) begin
            @(negedge clk); mem_wr = 1'b1; mem_addr = AW'(i); mem_wdata = DW'((i*37 + 11) & 255);
        end
        @(negedge clk); mem_wr = 1'b0;
        put_desc(0, 3, 0);
        put_desc(1, 5, 1);
        tx_en = 1'b1; idle(4);
        check("R1", "halted before restart", int'(out_valid), 0);

        // RESTART while disabled waits for enable
        cur_req = "R4"; tx_en = 1'b0;
        cmd(2'b01); idle(6);
        check("R4", "no output while disabled", int'(out_valid), 0);
        tx_en = 1'b1; idle(2);
        check("R4", "start after enable", int'(out_valid), 1);
        check("R4", "starts at cur_ptr", int'(cur_ptr), 0);

        // ring order and wrap, then polling of a not-ready descriptor
        cur_req = "R7"; idle(20);
        check("R7", "wrapped pointer", int'(cur_ptr), 0);
        cur_req = "R5";
        put_desc(2, 4, 0); idle(10);
        check("R5", "not-ready desc polled", int'(out_valid), 0);

        // back-pressure with a full-length frame
        cur_req = "R6"; bp_mode = 1;
        put_desc(0, 8, 0); idle(45);
        check("R6", "pointer after frame", int'(cur_ptr), 1);
        bp_mode = 0;

        // stop mid-frame and resend
        cur_req = "R8";
        put_desc(1, 8, 0); wait_valid(); idle(3);
        cmd(2'b00); idle(3);
        check("R8", "stopped output", int'(out_valid), 0);
        check("R8", "pointer kept", int'(cur_ptr), 1);
        idle(10);
        check("R8", "still idle", int'(out_valid), 0);
        cmd(2'b01); idle(30);
        check("R8", "resent and moved on", int'(cur_ptr), 3);

        // busy timing and a lost write
        cur_req = "R2";
        @(negedge clk); cmd_wr = 1'b1; cmd_op = 2'b11;
        @(negedge clk); check("R2", "busy first cycle", int'(cmd_busy), 1); cmd_op = 2'b00;
        @(negedge clk); check("R2", "busy second cycle", int'(cmd_busy), 1); cmd_wr = 1'b0;
        @(negedge clk); check("R2", "busy released", int'(cmd_busy), 0);
        put_desc(3, 2, 1); idle(10);
        check("R2", "ignored stop, frame sent", int'(cur_ptr), 0);

        // transmit error
        cur_req = "R9";
        put_desc(0, 8, 0); wait_valid(); idle(2);
        @(negedge clk); tx_err = 1'b1;
        @(negedge clk); tx_err = 1'b0;
        check("R9", "halted by error", int'(out_valid), 0);
        check("R9", "pointer kept", int'(cur_ptr), 0);
        idle(6);
        check("R9", "waits for restart", int'(out_valid), 0);
        cmd(2'b01); idle(20);
        check("R9", "resent after restart", int'(cur_ptr), 1);

        // enable drop mid-frame
        cur_req = "R12";
        put_desc(1, 8, 0); wait_valid(); idle(3);
        tx_en = 1'b0; idle(5);
        check("R12", "halted when disabled", int'(out_valid), 0);
        check("R12", "pointer kept", int'(cur_ptr), 1);
        tx_en = 1'b1; idle(20);
        check("R12", "resumed and finished", int'(cur_ptr), 2);

        // INIT while enabled rejected; NOP keeps flag
        cur_req = "R11";
        cmd(2'b10); idle(2);
        check("R11", "cmd_err set", int'(cmd_err), 1);
        check("R11", "pointer untouched", int'(cur_ptr), 2);
        cur_req = "R3";
        cmd(2'b11); idle(2);
        check("R3", "nop keeps cmd_err", int'(cmd_err), 1);
        cur_req = "R11";
        cmd(2'b01); idle(2);
        check("R11", "cmd_err cleared", int'(cmd_err), 0);

        // INIT while disabled
        cur_req = "R10";
        tx_en = 1'b0; cmd(2'b10); idle(3);
        check("R10", "pointer to base", int'(cur_ptr), 0);
        put_desc(0, 2, 0);
        tx_en = 1'b1; idle(5);
        check("R10", "run cleared", int'(out_valid), 0);
        cmd(2'b01); idle(10);
        check("R10", "restart from base", int'(cur_ptr), 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule